// File: doc/BRIEF.md
# Counter-Based Output Delay Scheduler

This block decides how long each arriving packet must wait in the fixed delay-line buffer of a four-input, four-output switch that queues traffic at its outputs. It keeps one occupancy counter per output, which holds how many slots of traffic are already queued for that output. When the slot-start strobe arrives, it visits every input once. Each valid request receives a delay equal to the current counter of its destination output, and that counter is then raised by the packet length. A request that would push the counter past the deepest delay the buffer can produce is refused.

The visit order begins at a position that advances by one input every slot, so no input is favoured over time. Inputs are visited one after another inside the same slot. A later packet to an output therefore sees the counter already raised by an earlier packet in that slot. After the requests are handled, every nonzero counter is lowered by one, because one slot of queued traffic drains. The per-input results are registered and are presented together with a slot-done strobe one cycle after slot start. They then hold until the next slot.

Top module: `slot_delay_sched`

## Requirements
- R1: After reset every output counter is zero, delay_o, accept_o, drop_o and slot_done_o are zero, and the first slot's visit starts at input 0.
- R2: A valid request that is accepted gets a delay equal to its destination output's counter at the moment it is visited.
- R3: Accepting a request adds its length, 1 to MAX_DELAY slots, to its destination counter, and later requests to that output see the raised value.
- R4: At the end of each slot every nonzero counter drops by one, and a counter at zero stays at zero.
- R5: Within one slot, requests are handled in visit order. A second request to the same output gets the first one's delay plus the first one's length, less nothing extra.
- R6: Slot number n after reset, counted from 0, begins its visit at input n mod N_IN and continues with increasing input numbers, wrapping from N_IN-1 to 0.
- R7: If counter plus length would exceed MAX_DELAY, the request is dropped. drop_o is set for that input, accept_o is clear, delay_o is 0 and the counter does not change. A counter never exceeds MAX_DELAY.
- R8: delay_o, accept_o and drop_o load on the clock edge that samples slot_start_i and hold until the next slot start. slot_done_o is high for exactly the cycle after each slot start.
- R9: An input whose valid bit is clear gets accept_o = 0, drop_o = 0 and delay_o = 0 and leaves every counter untouched. A slot with no requests only drains the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_start_i | input | 1 | One-cycle strobe that processes one time slot |
| req_valid_i | input | N_IN | New packet present, one bit per input |
| req_dest_i | input | N_IN*OUT_W | Destination output per input, input i in bits [i*OUT_W +: OUT_W] |
| req_len_i | input | N_IN*CNT_W | Packet length in slots per input, input i in bits [i*CNT_W +: CNT_W] |
| delay_o | output | N_IN*CNT_W | Assigned delay per input, same packing as req_len_i |
| accept_o | output | N_IN | Request accepted, per input |
| drop_o | output | N_IN | Request refused for lack of buffer depth, per input |
| slot_done_o | output | 1 | Results valid, one cycle after slot start |

## Verification
Two things can happen to one output counter in the same slot: several packets can be added to it, and the limit check can refuse a later packet because of an earlier one. The bench provokes this by sending two or more requests to one output in a single slot, with lengths that reach or pass MAX_DELAY. Because the visit order rotates, which input is refused depends on the slot number, so the same pattern is repeated across several slots. The results are judged against a model in the bench built from the requirements. That model tracks the counters, the drain step and the rotating start. A request sent in the following slot then shows that a refused packet left its counter unchanged.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // outcome of one request inside the scan
  typedef enum logic [1:0] {
    RES_IDLE   = 2'd0,
    RES_ACCEPT = 2'd1,
    RES_DROP   = 2'd2
  } req_res_e;
endpackage

// File: rtl/sched_rst_sync.sv
module sched_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_s_n = sync_q;
endmodule

// File: rtl/sched_rr_ptr.sv
module sched_rr_ptr #(
  parameter int N_IN = 4,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_start_i,
  output logic [IDX_W-1:0] start_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (slot_start_i) begin
      if (ptr_q == IDX_W'(N_IN - 1)) ptr_d = '0;
      else                           ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ptr_q <= '0;
    else if (slot_start_i) ptr_q <= ptr_d;
  end

  assign start_o = ptr_q;

  // R6: the start position advances by one (with wrap) on each slot
  assert_rotate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start_i |=> (ptr_q == (($past(ptr_q) == IDX_W'(N_IN - 1)) ? '0 : $past(ptr_q) + 1'b1)));

  assert_hold_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start_i |=> $stable(ptr_q));
endmodule

// File: rtl/sched_scan.sv
module sched_scan
  import sched_pkg::*;
#(
  parameter int N_IN      = 4,
  parameter int N_OUT     = 4,
  parameter int MAX_DELAY = 15,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int OUT_W = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int CNT_W = $clog2(MAX_DELAY + 1)
) (
  input  logic [IDX_W-1:0]       start_i,
  input  logic [N_IN-1:0]        valid_i,
  input  logic [N_IN*OUT_W-1:0]  dest_i,
  input  logic [N_IN*CNT_W-1:0]  len_i,
  input  logic [N_OUT*CNT_W-1:0] cnt_i,
  output logic [N_OUT*CNT_W-1:0] cnt_o,
  output logic [N_IN*CNT_W-1:0]  delay_o,
  output logic [N_IN-1:0]        accept_o,
  output logic [N_IN-1:0]        drop_o
);
  localparam logic [CNT_W:0] LIMIT = (CNT_W + 1)'(MAX_DELAY);

  logic [CNT_W-1:0] work   [N_OUT];
  req_res_e         res    [N_IN];
  logic [CNT_W-1:0] dly    [N_IN];

  // sequential visit: each stage sees the counters left by the previous one
  always_comb begin
    for (int o = 0; o < N_OUT; o++) work[o] = cnt_i[o*CNT_W +: CNT_W];
    for (int i = 0; i < N_IN; i++) begin
      res[i] = RES_IDLE;
      dly[i] = '0;
    end
    for (int k = 0; k < N_IN; k++) begin
      int             idx;
      int             d;
      logic [CNT_W:0] sum;
      idx = int'(start_i) + k;
      if (idx >= N_IN) idx = idx - N_IN;
      d = int'(dest_i[idx*OUT_W +: OUT_W]);
      sum = '0;
      if (valid_i[idx]) begin
        if (d >= N_OUT) begin
          res[idx] = RES_DROP;
        end else begin
          sum = {1'b0, work[d]} + {1'b0, len_i[idx*CNT_W +: CNT_W]};
          if (sum > LIMIT) begin
            res[idx] = RES_DROP;
          end else begin
            res[idx] = RES_ACCEPT;
            dly[idx] = work[d];
            work[d]  = sum[CNT_W-1:0];
          end
        end
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_IN; gi++) begin : g_res
      assign accept_o[gi]                  = (res[gi] == RES_ACCEPT);
      assign drop_o[gi]                    = (res[gi] == RES_DROP);
      assign delay_o[gi*CNT_W +: CNT_W]    = dly[gi];
    end
    for (gi = 0; gi < N_OUT; gi++) begin : g_cnt
      assign cnt_o[gi*CNT_W +: CNT_W] = work[gi];
    end
  endgenerate
endmodule

// File: rtl/sched_cnt_bank.sv
module sched_cnt_bank #(
  parameter int N_OUT     = 4,
  parameter int MAX_DELAY = 15,
  localparam int CNT_W = $clog2(MAX_DELAY + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   slot_start_i,
  input  logic [N_OUT*CNT_W-1:0] cnt_scan_i,
  output logic [N_OUT*CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q [N_OUT];
  logic [CNT_W-1:0] cnt_d [N_OUT];

  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      logic [CNT_W-1:0] v;
      v = cnt_scan_i[o*CNT_W +: CNT_W];
      cnt_d[o] = (v != '0) ? v - 1'b1 : '0;
    end
  end

  genvar go;
  generate
    for (go = 0; go < N_OUT; go++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q[go] <= '0;
        else if (slot_start_i) cnt_q[go] <= cnt_d[go];
      end
      assign cnt_o[go*CNT_W +: CNT_W] = cnt_q[go];

      // R7: the counter stays within the buffer depth
      assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q[go] <= CNT_W'(MAX_DELAY));

      // R4: an untouched nonzero counter drains by exactly one per slot
      assert_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start_i && (cnt_scan_i[go*CNT_W +: CNT_W] == cnt_q[go]) && (cnt_q[go] != '0))
        |=> (cnt_q[go] == $past(cnt_q[go]) - 1'b1));

      // R9: a counter only changes on a slot
      assert_hold_cnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_start_i |=> $stable(cnt_q[go]));
    end
  endgenerate
endmodule

// File: rtl/slot_delay_sched.sv
module slot_delay_sched #(
  parameter int N_IN      = 4,
  parameter int N_OUT     = 4,
  parameter int MAX_DELAY = 15,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int OUT_W = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int CNT_W = $clog2(MAX_DELAY + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot_start_i,
  input  logic [N_IN-1:0]       req_valid_i,
  input  logic [N_IN*OUT_W-1:0] req_dest_i,
  input  logic [N_IN*CNT_W-1:0] req_len_i,
  output logic [N_IN*CNT_W-1:0] delay_o,
  output logic [N_IN-1:0]       accept_o,
  output logic [N_IN-1:0]       drop_o,
  output logic                  slot_done_o
);
  logic                   rst_s_n;
  logic [IDX_W-1:0]       start_idx;
  logic [N_OUT*CNT_W-1:0] cnt_cur;
  logic [N_OUT*CNT_W-1:0] cnt_scan;
  logic [N_IN*CNT_W-1:0]  delay_c;
  logic [N_IN-1:0]        accept_c;
  logic [N_IN-1:0]        drop_c;

  logic [N_IN*CNT_W-1:0]  delay_q;
  logic [N_IN-1:0]        accept_q;
  logic [N_IN-1:0]        drop_q;
  logic                   done_q;

  sched_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  sched_rr_ptr #(.N_IN(N_IN)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .slot_start_i (slot_start_i),
    .start_o      (start_idx)
  );

  sched_scan #(.N_IN(N_IN), .N_OUT(N_OUT), .MAX_DELAY(MAX_DELAY)) u_scan (
    .start_i  (start_idx),
    .valid_i  (req_valid_i),
    .dest_i   (req_dest_i),
    .len_i    (req_len_i),
    .cnt_i    (cnt_cur),
    .cnt_o    (cnt_scan),
    .delay_o  (delay_c),
    .accept_o (accept_c),
    .drop_o   (drop_c)
  );

  sched_cnt_bank #(.N_OUT(N_OUT), .MAX_DELAY(MAX_DELAY)) u_bank (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .slot_start_i (slot_start_i),
    .cnt_scan_i   (cnt_scan),
    .cnt_o        (cnt_cur)
  );

  // result registers, loaded once per slot
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      delay_q  <= '0;
      accept_q <= '0;
      drop_q   <= '0;
    end else if (slot_start_i) begin
      delay_q  <= delay_c;
      accept_q <= accept_c;
      drop_q   <= drop_c;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) done_q <= 1'b0;
    else          done_q <= slot_start_i;
  end

  assign delay_o     = delay_q;
  assign accept_o    = accept_q;
  assign drop_o      = drop_q;
  assign slot_done_o = done_q;

  // R8: strobe follows slot start by one cycle and lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    slot_start_i |=> slot_done_o);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !slot_start_i |=> !slot_done_o);

  // R8: results hold between slots
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !slot_start_i |=> ($stable(delay_o) && $stable(accept_o) && $stable(drop_o)));

  // R7: one request is never both accepted and dropped
  assert_acc_drop_excl_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (accept_o & drop_o) == '0);

  // R9: a result flag only appears for an input that requested
  assert_flag_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    slot_start_i |=> (((accept_o | drop_o) & ~$past(req_valid_i)) == '0));
endmodule

// File: tb/tb_slot_delay_sched.sv
`timescale 1ns/1ps
module tb_slot_delay_sched;
  localparam int N_IN  = 4;
  localparam int N_OUT = 4;
  localparam int MAXD  = 15;
  localparam int OUT_W = 2;
  localparam int CNT_W = 4;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  slot_start_i;
  logic [N_IN-1:0]       req_valid_i;
  logic [N_IN*OUT_W-1:0] req_dest_i;
  logic [N_IN*CNT_W-1:0] req_len_i;
  logic [N_IN*CNT_W-1:0] delay_o;
  logic [N_IN-1:0]       accept_o;
  logic [N_IN-1:0]       drop_o;
  logic                  slot_done_o;

  always #2.5 clk = ~clk;

  slot_delay_sched #(.N_IN(N_IN), .N_OUT(N_OUT), .MAX_DELAY(MAXD)) dut (
    .clk(clk), .rst_n(rst_n), .slot_start_i(slot_start_i),
    .req_valid_i(req_valid_i), .req_dest_i(req_dest_i), .req_len_i(req_len_i),
    .delay_o(delay_o), .accept_o(accept_o), .drop_o(drop_o),
    .slot_done_o(slot_done_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference state built from the requirements
  int mcnt [N_OUT];
  int mstart;

  // per-slot stimulus
  int tv [N_IN];
  int td [N_IN];
  int tl [N_IN];
  int edel [N_IN];
  int eacc [N_IN];
  int edrp [N_IN];

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_req();
    for (int i = 0; i < N_IN; i++) begin tv[i] = 0; td[i] = 0; tl[i] = 1; end
  endtask

  task automatic check_results(string tag);
    for (int i = 0; i < N_IN; i++) begin
      chk(tag, $sformatf("delay in%0d", i), int'(delay_o[i*CNT_W +: CNT_W]), edel[i]);
      chk(tag, $sformatf("accept in%0d", i), int'(accept_o[i]), eacc[i]);
      chk(tag, $sformatf("drop in%0d", i), int'(drop_o[i]), edrp[i]);
    end
  endtask

  // run one slot with tv/td/tl and check it
  task automatic do_slot(string tag);
    @(negedge clk);
    for (int i = 0; i < N_IN; i++) begin
      req_valid_i[i]                = tv[i][0];
      req_dest_i[i*OUT_W +: OUT_W]  = OUT_W'(td[i]);
      req_len_i[i*CNT_W +: CNT_W]   = CNT_W'(tl[i]);
      edel[i] = 0; eacc[i] = 0; edrp[i] = 0;
    end
    slot_start_i = 1'b1;
    for (int k = 0; k < N_IN; k++) begin
      int idx;
      idx = (mstart + k) % N_IN;
      if (tv[idx] != 0) begin
        if (mcnt[td[idx]] + tl[idx] > MAXD) edrp[idx] = 1;
        else begin
          eacc[idx] = 1;
          edel[idx] = mcnt[td[idx]];
          mcnt[td[idx]] += tl[idx];
        end
      end
    end
    for (int o = 0; o < N_OUT; o++) if (mcnt[o] > 0) mcnt[o]--;
    mstart = (mstart + 1) % N_IN;
    @(negedge clk);
    slot_start_i = 1'b0;
    req_valid_i  = '0;
    chk(tag, "slot_done after start (R8)", int'(slot_done_o), 1);
    check_results(tag);
    @(negedge clk);
    chk("R8", "slot_done second cycle", int'(slot_done_o), 0);
    check_results("R8");
  endtask

  task automatic t_reset();
    chk("R1", "slot_done", int'(slot_done_o), 0);
    chk("R1", "delay_o", int'(delay_o), 0);
    chk("R1", "accept_o", int'(accept_o), 0);
    chk("R1", "drop_o", int'(drop_o), 0);
    // all four to one output, length 1: slot 0 must start at input 0
    clear_req();
    for (int i = 0; i < N_IN; i++) begin tv[i] = 1; td[i] = 1; end
    do_slot("R1");
    chk("R1", "input0 first in slot 0", int'(delay_o[0 +: CNT_W]), 0);
    chk("R1", "input3 last in slot 0", int'(delay_o[3*CNT_W +: CNT_W]), 3);
  endtask

  task automatic drain_all();
    clear_req();
    for (int s = 0; s < MAXD + 1; s++) do_slot("R4");
  endtask

  task automatic t_single();
    drain_all();
    clear_req();
    tv[0] = 1; td[0] = 2; tl[0] = 5;
    do_slot("R2");
    clear_req();
    tv[1] = 1; td[1] = 2; tl[1] = 1;
    do_slot("R3");
    chk("R3", "delay after length 5 and one drain", int'(delay_o[1*CNT_W +: CNT_W]), 4);
  endtask

  task automatic t_idle();
    clear_req();
    for (int s = 0; s < 8; s++) do_slot("R9");
    clear_req();
    tv[2] = 1; td[2] = 2; tl[2] = 2;
    do_slot("R4");
    chk("R4", "counter floored at zero", int'(delay_o[2*CNT_W +: CNT_W]), 0);
  endtask

  task automatic t_same_out();
    drain_all();
    clear_req();
    tv[0] = 1; td[0] = 3; tl[0] = 3;
    tv[2] = 1; td[2] = 3; tl[2] = 4;
    tv[1] = 1; td[1] = 0; tl[1] = 2;
    do_slot("R5");
    clear_req();
    tv[0] = 1; td[0] = 3; tl[0] = 2;
    tv[1] = 1; td[1] = 3; tl[1] = 2;
    tv[3] = 1; td[3] = 3; tl[3] = 2;
    do_slot("R5");
  endtask

  task automatic t_rotate();
    for (int s = 0; s < N_IN + 1; s++) begin
      int st;
      drain_all();
      st = mstart;
      clear_req();
      for (int i = 0; i < N_IN; i++) begin tv[i] = 1; td[i] = 0; end
      do_slot("R6");
      for (int i = 0; i < N_IN; i++)
        chk("R6", $sformatf("order delay in%0d", i),
            int'(delay_o[i*CNT_W +: CNT_W]), (i - st + N_IN) % N_IN);
    end
  endtask

  task automatic t_drop();
    for (int s = 0; s < N_IN; s++) begin
      drain_all();
      clear_req();
      tv[0] = 1; td[0] = 3; tl[0] = MAXD;
      tv[1] = 1; td[1] = 3; tl[1] = 1;
      tv[2] = 1; td[2] = 1; tl[2] = MAXD;
      do_slot("R7");
      clear_req();
      tv[3] = 1; td[3] = 3; tl[3] = 2;
      do_slot("R7");
      clear_req();
      tv[(s + 1) % N_IN] = 1; td[(s + 1) % N_IN] = 3; tl[(s + 1) % N_IN] = 1;
      do_slot("R7");
    end
  endtask

  task automatic t_hold();
    clear_req();
    tv[1] = 1; td[1] = 0; tl[1] = 3;
    do_slot("R8");
    repeat (5) @(negedge clk);
    check_results("R8");
    chk("R8", "slot_done idle", int'(slot_done_o), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    slot_start_i = 1'b0;
    req_valid_i = '0;
    req_dest_i = '0;
    req_len_i = '0;
    for (int o = 0; o < N_OUT; o++) mcnt[o] = 0;
    mstart = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_idle();
    t_same_out();
    t_rotate();
    t_drop();
    t_hold();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule